// File: doc/BRIEF.md
# DAC Conversion Sequencer

This block paces the conversions of a single analog output channel. Software writes an operating mode. Hardware start and stop trigger pulses then move a trigger state machine through its phases. While that machine is running, a programmable clock divider produces one conversion strobe per divided period. After a stop trigger, a programmed number of further conversions is issued before the channel either finishes or re-arms for the next start trigger.

There are five mode codes, each with its own effect on the counters and the trigger state machine:

- The power-on mode requires a converter initialization interval before any conversion.
- Reset clears everything.
- Pause freezes everything in place.
- The two run modes differ only in what follows the post-stop conversions.

A conversion counter, the live divider count and the remaining post-stop count can be read back. Four sticky event flags, each with an enable, combine into a single interrupt line.

Top module: `dac_seq_ctrl`

## Requirements
- R1: After reset the mode reads 4 (Uninitialized), the trigger state reads 0 (idle), the conversion, divider and post-stop counts and the event flags are 0, and no strobe is issued.
- R2: In mode 4, start and stop triggers have no effect: the trigger state stays 0 and no strobe is issued.
- R3: A valid write that leaves mode 4 raises init_busy for exactly INIT_CYCLES clocks. Until init_busy falls, the trigger state stays 0 and no strobe is issued, even in a run mode with the start trigger held.
- R4: Mode 1 (Paused) freezes the divider count, conversion count, post-stop count and trigger state, issues no strobe and ignores triggers. One clock after mode 0 (Reset) is entered, all counts are 0 and the trigger state is 0.
- R5: In a run mode (2 single-shot, 3 re-arm) with initialization complete, the idle state (0) advances to wait-for-start (1) on the next clock. A start trigger moves it to running (2). A stop trigger seen in state 1 is ignored.
- R6: A stop trigger in state 2 enters post-stop (3) with post_left loaded from post_set. Exactly post_set further strobes follow. In mode 2 the machine then enters done (4), which holds with no strobes until mode 0 or 4 is written.
- R7: In states 2 and 3 a strobe is issued each time the divider count is zero. The divider reloads div_set on zero and otherwise decrements, so strobes are div_set+1 clocks apart.
- R8: In mode 3, once the post-stop strobes are issued, the machine returns to state 1 and a new start trigger resumes running.
- R9: conv_count rises by one for each strobe.
- R10: irq_stat bit 0 = conversion, bit 1 = start, bit 2 = stop, bit 3 = error. Each bit is sticky and is cleared by a 1 on the matching irq_clr bit; a new event in the same clock wins. irq_out is the OR of irq_stat AND irq_en.
- R11: irq_stat bit 3 is set when a strobe is issued while src_empty is high, and only then.
- R12: A mode write with a code above 4 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Mode write strobe |
| mode_in | input | 4 | Mode code to write |
| div_set | input | DIV_W | Divider setting (period minus one) |
| post_set | input | PS_W | Conversions to issue after the stop trigger |
| start_trig | input | 1 | Start trigger |
| stop_trig | input | 1 | Stop trigger |
| src_empty | input | 1 | Sample source has no data |
| irq_en | input | 4 | Event flag enables |
| irq_clr | input | 4 | Write-one-to-clear for event flags |
| conv_strobe | output | 1 | Conversion strobe |
| mode_q | output | 4 | Current mode code |
| trig_state | output | 3 | Trigger state code |
| conv_count | output | CNT_W | Conversions issued |
| div_count | output | DIV_W | Live divider count |
| post_left | output | PS_W | Post-stop conversions remaining |
| init_busy | output | 1 | Converter initialization in progress |
| irq_stat | output | 4 | Sticky event flags |
| irq_out | output | 1 | Combined interrupt |

## Verification
On every cycle, the assertions check the following:
- The divider decrements and reloads correctly, and stays frozen in pause.
- No stop can reach post-stop from wait-for-start.
- The remaining count steps down once per post-stop strobe.
- Done holds, and re-arm returns to waiting.
- No strobe is issued before initialization completes.
- The event flags stay sticky.

Only the bench's scenarios can show the rest:
- The exact post-stop strobe count and the strobe spacing, across a sweep of divider and post-stop settings in both run modes.
- The length of the initialization interval.
- That pause followed by resume continues from the same state.
- The enable masking on the interrupt line.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;
    localparam logic [3:0] MODE_RESET  = 4'h0;
    localparam logic [3:0] MODE_PAUSE  = 4'h1;
    localparam logic [3:0] MODE_SINGLE = 4'h2;
    localparam logic [3:0] MODE_REARM  = 4'h3;
    localparam logic [3:0] MODE_UNINIT = 4'h4;

    typedef enum logic [2:0] {
        TS_IDLE = 3'd0,
        TS_WAIT = 3'd1,
        TS_RUN  = 3'd2,
        TS_POST = 3'd3,
        TS_DONE = 3'd4
    } tstate_e;

    localparam int EVT_CONV  = 0;
    localparam int EVT_START = 1;
    localparam int EVT_STOP  = 2;
    localparam int EVT_ERR   = 3;
    localparam int EVT_N     = 4;
endpackage

// File: rtl/dac_seq_div.sv
module dac_seq_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [DIV_W-1:0] div_set,
    output logic             tick,
    output logic [DIV_W-1:0] count
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_t;

    div_t div_d, div_q;

    always_comb begin
        div_d = div_q;
        if (clear) begin
            div_d.cnt = '0;
        end else if (run) begin
            if (div_q.cnt == '0) div_d.cnt = div_set;
            else                 div_d.cnt = div_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign tick  = run && !clear && (div_q.cnt == '0);
    assign count = div_q.cnt;

    assert_div_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clear && div_q.cnt != '0) |=> (div_q.cnt == $past(div_q.cnt) - 1'b1));
    assert_div_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clear && div_q.cnt == '0) |=> (div_q.cnt == $past(div_set)));
    assert_div_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clear) |=> $stable(div_q.cnt));
endmodule

// File: rtl/dac_seq_fsm.sv
module dac_seq_fsm
    import dac_seq_pkg::*;
#(
    parameter int PS_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            armed,
    input  logic            rearm,
    input  logic            start_trig,
    input  logic            stop_trig,
    input  logic            tick,
    input  logic [PS_W-1:0] post_set,
    output tstate_e         state,
    output logic            strobe,
    output logic            start_evt,
    output logic            stop_evt,
    output logic [PS_W-1:0] remaining
);
    typedef struct packed {
        tstate_e         st;
        logic [PS_W-1:0] rem;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    logic strobe_w, start_w, stop_w;

    always_comb begin
        fsm_d    = fsm_q;
        start_w  = 1'b0;
        stop_w   = 1'b0;
        strobe_w = armed && tick &&
                   (fsm_q.st == TS_RUN || (fsm_q.st == TS_POST && fsm_q.rem != '0));
        if (clear) begin
            fsm_d.st  = TS_IDLE;
            fsm_d.rem = '0;
        end else if (armed) begin
            case (fsm_q.st)
                TS_IDLE: fsm_d.st = TS_WAIT;
                TS_WAIT: begin
                    if (start_trig) begin
                        fsm_d.st = TS_RUN;
                        start_w  = 1'b1;
                    end
                end
                TS_RUN: begin
                    if (stop_trig) begin
                        fsm_d.st  = TS_POST;
                        fsm_d.rem = post_set;
                        stop_w    = 1'b1;
                    end
                end
                TS_POST: begin
                    if (fsm_q.rem == '0)  fsm_d.st  = rearm ? TS_WAIT : TS_DONE;
                    else if (strobe_w)    fsm_d.rem = fsm_q.rem - 1'b1;
                end
                default: fsm_d.st = TS_DONE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= '{st: TS_IDLE, rem: '0};
        else        fsm_q <= fsm_d;
    end

    assign state     = fsm_q.st;
    assign strobe    = strobe_w;
    assign start_evt = start_w;
    assign stop_evt  = stop_w;
    assign remaining = fsm_q.rem;

    assert_stop_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == TS_WAIT) |=> (fsm_q.st != TS_POST));
    assert_post_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == TS_POST && strobe && !clear) |=> (fsm_q.rem == $past(fsm_q.rem) - 1'b1));
    assert_done_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == TS_DONE && !clear) |=> (fsm_q.st == TS_DONE));
    assert_rearm_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == TS_POST && fsm_q.rem == '0 && armed && rearm && !clear) |=> (fsm_q.st == TS_WAIT));
endmodule

// File: rtl/dac_seq_ctrl.sv
module dac_seq_ctrl
    import dac_seq_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int CNT_W       = 16,
    parameter int PS_W        = 8,
    parameter int INIT_CYCLES = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_wr,
    input  logic [3:0]       mode_in,
    input  logic [DIV_W-1:0] div_set,
    input  logic [PS_W-1:0]  post_set,
    input  logic             start_trig,
    input  logic             stop_trig,
    input  logic             src_empty,
    input  logic [3:0]       irq_en,
    input  logic [3:0]       irq_clr,
    output logic             conv_strobe,
    output logic [3:0]       mode_q,
    output logic [2:0]       trig_state,
    output logic [CNT_W-1:0] conv_count,
    output logic [DIV_W-1:0] div_count,
    output logic [PS_W-1:0]  post_left,
    output logic             init_busy,
    output logic [3:0]       irq_stat,
    output logic             irq_out
);
    localparam int INIT_W = $clog2(INIT_CYCLES + 1);

    typedef struct packed {
        logic [3:0]       mode;
        logic             busy;
        logic             ready;
        logic [INIT_W-1:0] icnt;
        logic [CNT_W-1:0] conv;
        logic [EVT_N-1:0] evt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic    clear_w, go_w, armed_w, tick_w, strobe_w, start_evt_w, stop_evt_w;
    tstate_e state_w;
    logic [EVT_N-1:0] evt_set_w;

    assign clear_w = (ctl_q.mode == MODE_RESET) || (ctl_q.mode == MODE_UNINIT);
    assign go_w    = (ctl_q.mode == MODE_SINGLE) || (ctl_q.mode == MODE_REARM);
    assign armed_w = go_w && ctl_q.ready;

    dac_seq_div #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear_w),
        .run     (armed_w),
        .div_set (div_set),
        .tick    (tick_w),
        .count   (div_count)
    );

    dac_seq_fsm #(.PS_W(PS_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear_w),
        .armed      (armed_w),
        .rearm      (ctl_q.mode == MODE_REARM),
        .start_trig (start_trig),
        .stop_trig  (stop_trig),
        .tick       (tick_w),
        .post_set   (post_set),
        .state      (state_w),
        .strobe     (strobe_w),
        .start_evt  (start_evt_w),
        .stop_evt   (stop_evt_w),
        .remaining  (post_left)
    );

    always_comb begin
        evt_set_w            = '0;
        evt_set_w[EVT_CONV]  = strobe_w;
        evt_set_w[EVT_START] = start_evt_w;
        evt_set_w[EVT_STOP]  = stop_evt_w;
        evt_set_w[EVT_ERR]   = strobe_w && src_empty;
    end

    always_comb begin
        ctl_d = ctl_q;
        // initialization interval countdown
        if (ctl_q.busy) begin
            if (ctl_q.icnt == '0) begin
                ctl_d.busy  = 1'b0;
                ctl_d.ready = 1'b1;
            end else begin
                ctl_d.icnt = ctl_q.icnt - 1'b1;
            end
        end
        // mode write; codes above the last mode are dropped
        if (mode_wr && mode_in <= MODE_UNINIT) begin
            ctl_d.mode = mode_in;
            if (mode_in == MODE_UNINIT) begin
                ctl_d.busy  = 1'b0;
                ctl_d.ready = 1'b0;
                ctl_d.icnt  = '0;
            end else if (ctl_q.mode == MODE_UNINIT) begin
                ctl_d.busy  = 1'b1;
                ctl_d.ready = 1'b0;
                ctl_d.icnt  = INIT_W'(INIT_CYCLES - 1);
            end
        end
        // conversion counter
        if (clear_w)       ctl_d.conv = '0;
        else if (strobe_w) ctl_d.conv = ctl_q.conv + 1'b1;
        // sticky event flags, set beats clear
        ctl_d.evt = (ctl_q.evt & ~irq_clr) | evt_set_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.mode <= MODE_UNINIT;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign conv_strobe = strobe_w;
    assign mode_q      = ctl_q.mode;
    assign trig_state  = state_w;
    assign conv_count  = ctl_q.conv;
    assign init_busy   = ctl_q.busy;
    assign irq_stat    = ctl_q.evt;
    assign irq_out     = |(ctl_q.evt & irq_en);

    assert_strobe_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_strobe |-> (ctl_q.ready && !ctl_q.busy));
    assert_uninit_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.mode == MODE_UNINIT) |=> (state_w == TS_IDLE));
    assert_pause_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.mode == MODE_PAUSE) |=> ($stable(ctl_q.conv) && $stable(state_w)));
    assert_reset_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.mode == MODE_RESET) |=> (ctl_q.conv == '0 && div_count == '0 && state_w == TS_IDLE));
    assert_bad_mode_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && mode_in > MODE_UNINIT) |=> $stable(ctl_q.mode));
    assert_evt_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ctl_q.evt & ~irq_clr)) |=> ((ctl_q.evt & $past(ctl_q.evt & ~irq_clr)) == $past(ctl_q.evt & ~irq_clr)));
endmodule

// File: tb/dac_seq_ctrl_tb.sv
module dac_seq_ctrl_tb;
    localparam int DIV_W = 8;
    localparam int CNT_W = 16;
    localparam int PS_W  = 8;
    localparam int INIT  = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mode_wr = 1'b0;
    logic [3:0]       mode_in = 4'h0;
    logic [DIV_W-1:0] div_set = '0;
    logic [PS_W-1:0]  post_set = '0;
    logic             start_trig = 1'b0;
    logic             stop_trig = 1'b0;
    logic             src_empty = 1'b0;
    logic [3:0]       irq_en = 4'h0;
    logic [3:0]       irq_clr = 4'h0;
    logic             conv_strobe;
    logic [3:0]       mode_q;
    logic [2:0]       trig_state;
    logic [CNT_W-1:0] conv_count;
    logic [DIV_W-1:0] div_count;
    logic [PS_W-1:0]  post_left;
    logic             init_busy;
    logic [3:0]       irq_stat;
    logic             irq_out;

    dac_seq_ctrl #(.DIV_W(DIV_W), .CNT_W(CNT_W), .PS_W(PS_W), .INIT_CYCLES(INIT)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_in(mode_in),
        .div_set(div_set), .post_set(post_set), .start_trig(start_trig),
        .stop_trig(stop_trig), .src_empty(src_empty), .irq_en(irq_en),
        .irq_clr(irq_clr), .conv_strobe(conv_strobe), .mode_q(mode_q),
        .trig_state(trig_state), .conv_count(conv_count), .div_count(div_count),
        .post_left(post_left), .init_busy(init_busy), .irq_stat(irq_stat),
        .irq_out(irq_out)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // strobe monitor, sampled at the falling edge
    int cyc = 0;
    int strobe_total = 0;
    int last_sc = -1;
    int gap_bad = 0;
    int gap_epoch = 0;
    int cur_div = 0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (conv_strobe) begin
            if (last_sc >= gap_epoch && ((cyc - last_sc) % (cur_div + 1)) != 0)
                gap_bad = gap_bad + 1;
            strobe_total = strobe_total + 1;
            last_sc = cyc;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic write_mode(input logic [3:0] m);
        mode_in = m;
        mode_wr = 1'b1;
        step(1);
        mode_wr = 1'b0;
    endtask

    task automatic pulse_start();
        start_trig = 1'b1;
        step(1);
        start_trig = 1'b0;
    endtask

    task automatic pulse_stop();
        stop_trig = 1'b1;
        step(1);
        stop_trig = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
    end

    initial begin
        int n, bad, base, s0, sc, cc, dc, pl, ts, endst;
        gap_epoch = 1 << 30;
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1 reset state
        chk(mode_q == 4'h4, "R1", "mode", mode_q, 4);
        chk(trig_state == 3'd0, "R1", "state", trig_state, 0);
        chk(conv_count == 0 && div_count == 0 && post_left == 0, "R1", "counts", conv_count, 0);
        chk(irq_stat == 4'h0 && !irq_out, "R1", "flags", irq_stat, 0);
        chk(!conv_strobe && !init_busy, "R1", "strobe/busy", conv_strobe, 0);

        // R2 triggers ignored while uninitialized
        pulse_start();
        pulse_stop();
        step(3);
        chk(trig_state == 3'd0, "R2", "state", trig_state, 0);
        chk(strobe_total == 0, "R2", "strobes", strobe_total, 0);

        // R12 invalid mode codes
        write_mode(4'h9);
        chk(mode_q == 4'h4, "R12", "mode after 9", mode_q, 4);
        write_mode(4'h5);
        chk(mode_q == 4'h4, "R12", "mode after 5", mode_q, 4);

        // R3 initialization gating with start held high
        start_trig = 1'b1;
        write_mode(4'h2);
        n = 0;
        bad = 0;
        while (init_busy && n < 100) begin
            step(1);
            n++;
            if (trig_state != 3'd0) bad++;
        end
        start_trig = 1'b0;
        chk(n == INIT, "R3", "busy cycles", n, INIT);
        chk(bad == 0, "R3", "state left idle during init", bad, 0);
        chk(strobe_total == 0, "R3", "strobes during init", strobe_total, 0);
        step(1);
        chk(trig_state == 3'd1, "R5", "idle to wait", trig_state, 1);

        // sweep divider, post-stop count and both run modes
        for (int m = 2; m <= 3; m++) begin
            for (int d = 0; d <= 3; d++) begin
                for (int p = 0; p <= 3; p++) begin
                    write_mode(4'h0);
                    div_set  = DIV_W'(d);
                    post_set = PS_W'(p);
                    cur_div  = d;
                    step(2);
                    gap_epoch = cyc + 1;
                    base = strobe_total;
                    write_mode(4'(m));
                    step(3);
                    chk(trig_state == 3'd1, "R5", "wait state", trig_state, 1);
                    pulse_stop();
                    step(2);
                    chk(trig_state == 3'd1, "R5", "stop before start ignored", trig_state, 1);
                    chk(strobe_total == base, "R5", "no strobes in wait", strobe_total - base, 0);
                    pulse_start();
                    chk(trig_state == 3'd2, "R5", "running", trig_state, 2);
                    step(10);
                    chk(strobe_total - base >= 1, "R7", "run strobes", strobe_total - base, 1);
                    chk(int'(conv_count) == strobe_total - base, "R9", "conv count", conv_count, strobe_total - base);
                    pulse_stop();
                    s0 = strobe_total;
                    endst = (m == 2) ? 4 : 1;
                    for (int k = 0; k < 60; k++) begin
                        if (trig_state == 3'(endst)) break;
                        step(1);
                    end
                    chk(trig_state == 3'(endst), "R6", "end state", trig_state, endst);
                    chk(strobe_total - s0 == p, "R6", "post-stop strobes", strobe_total - s0, p);
                    s0 = strobe_total;
                    step(3 * (d + 1) + 4);
                    chk(strobe_total == s0, "R6", "quiet after post-stop", strobe_total - s0, 0);
                    if (m == 2) begin
                        chk(trig_state == 3'd4, "R6", "done holds", trig_state, 4);
                    end else begin
                        chk(trig_state == 3'd1, "R8", "rearmed wait", trig_state, 1);
                        pulse_start();
                        chk(trig_state == 3'd2, "R8", "restart", trig_state, 2);
                        step(2 * (d + 1) + 1);
                        chk(strobe_total > s0, "R8", "strobes after restart", strobe_total - s0, 1);
                    end
                    chk(int'(conv_count) == strobe_total - base, "R9", "conv count end", conv_count, strobe_total - base);
                end
            end
        end
        chk(gap_bad == 0, "R7", "strobe spacing", gap_bad, 0);
        gap_epoch = 1 << 30;

        // R4 pause holds all state, then reset clears
        write_mode(4'h0);
        div_set  = 8'd2;
        post_set = 8'd3;
        write_mode(4'h2);
        step(2);
        pulse_start();
        step(7);
        write_mode(4'h1);
        sc = strobe_total; cc = conv_count; dc = div_count; pl = post_left; ts = trig_state;
        pulse_stop();
        pulse_start();
        step(20);
        chk(strobe_total == sc, "R4", "no strobes paused", strobe_total - sc, 0);
        chk(int'(conv_count) == cc, "R4", "conv frozen", conv_count, cc);
        chk(int'(div_count) == dc, "R4", "div frozen", div_count, dc);
        chk(int'(post_left) == pl && int'(trig_state) == ts, "R4", "state frozen", trig_state, ts);
        write_mode(4'h2);
        step(5);
        chk(trig_state == 3'd2, "R4", "resumed running", trig_state, 2);
        chk(int'(conv_count) > cc, "R4", "conversions resumed", conv_count, cc + 1);
        write_mode(4'h0);
        step(1);
        chk(conv_count == 0 && div_count == 0 && trig_state == 3'd0, "R4", "reset clears", conv_count, 0);

        // R10 / R11 event flags
        chk(irq_stat[3] == 1'b0, "R11", "no error with data present", irq_stat[3], 0);
        chk(irq_stat[2:0] == 3'b111, "R10", "events seen", irq_stat, 7);
        chk(irq_out == 1'b0, "R10", "masked line", irq_out, 0);
        irq_clr = 4'hF;
        step(1);
        irq_clr = 4'h0;
        chk(irq_stat == 4'h0, "R10", "write one clears", irq_stat, 0);
        irq_en = 4'b0010;
        write_mode(4'h2);
        step(3);
        chk(irq_out == 1'b0, "R10", "line low before start", irq_out, 0);
        pulse_start();
        chk(irq_stat[1] == 1'b1 && irq_out == 1'b1, "R10", "start flag and line", irq_stat, 2);
        src_empty = 1'b1;
        step(8);
        src_empty = 1'b0;
        chk(irq_stat[3] == 1'b1, "R11", "error on empty", irq_stat[3], 1);
        chk(irq_stat[0] == 1'b1, "R10", "conversion flag", irq_stat[0], 1);
        irq_clr = 4'b0010;
        step(1);
        irq_clr = 4'h0;
        chk(irq_stat[1] == 1'b0 && irq_out == 1'b0, "R10", "start cleared", irq_stat, 0);
        chk(irq_stat[3] == 1'b1, "R10", "other flags kept", irq_stat[3], 1);

        summary();
    end
endmodule